// File: doc/BRIEF.md
# Push-Button Debouncer with Dwell Qualification

This block turns one bouncing mechanical button line into a clean level and a pair of single-cycle event strobes. The raw line is first brought into the clock domain through a short flop chain. A four-state machine then tracks it: two resting states, one for each settled level, and two qualifying states, one for each direction of change. A dwell counter runs only while a qualifying state is held. The settled level flips only when the new input value has been held without a break for the whole dwell window.

The dwell window is `DWELL_TICKS` ticks long. A tick comes once every `PRESCALE` clock cycles, so long windows (tens of milliseconds) need only two small counters and never one wide one. The prescaler is held at zero in the resting states. This starts every window on a fixed phase, so the dwell is exactly `DWELL_TICKS * PRESCALE` cycles. One instance serves one button. A board with several buttons uses one instance per button.

Below, D stands for `DWELL_TICKS * PRESCALE`. Input values are sampled at rising clock edges.

Top module: `button_debouncer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `btn_level`, `btn_press` and `btn_release` are 0. This holds even if reset is applied in the middle of a qualification.
- R2: `btn_raw` passes through a two-flop synchroniser before the state machine sees it. Take an input that rises at sampling edge k and then stays high from a settled-low state. `btn_level` is then 1 just after edge k+D+2 and not before.
- R3: The settled level changes only after the synchronised input has differed from it for D+1 consecutive cycles: one cycle to leave the resting state, then D cycles of dwell.
- R4: If the input goes back to the settled level during a qualifying state, the machine returns to the previous resting state and the dwell count restarts from zero. A pulse of D cycles or fewer never changes `btn_level`.
- R5: `btn_press` is high for exactly one cycle: the first cycle in which `btn_level` reads 1 after a rising qualification.
- R6: `btn_release` is high for exactly one cycle: the first cycle in which `btn_level` reads 0 after a falling qualification.
- R7: While a qualification is in progress, `btn_level` keeps the old settled value. It reads 1 in the settled-high and going-low states, and 0 in the settled-low and going-high states.
- R8: The dwell length scales with both parameters. With `PRESCALE` = 1 the counter advances every cycle. With a larger prescale it advances once per `PRESCALE` cycles, and the window becomes `DWELL_TICKS * PRESCALE` cycles.
- R9: `btn_press` and `btn_release` are never high in the same cycle, and `btn_level` changes only in a cycle that carries one of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_raw | input | 1 | Raw button line, asynchronous and bouncing |
| btn_level | output | 1 | Debounced level |
| btn_press | output | 1 | One-cycle strobe when the level becomes 1 |
| btn_release | output | 1 | One-cycle strobe when the level becomes 0 |

## Verification
The assertions assume that `btn_raw` may change at any time but that `rst` is synchronous and held for at least one edge. They also assume that the prescaler and the dwell counter only ever start from the cleared values that the resting states force. The stimulus changes the raw line only on falling clock edges, which keeps it inside these assumptions. It drives pulses of every length around the D+1 threshold in both directions, a pseudo-random bounce burst, and a reset in the middle of a qualification. Two instances share the same input: one with a prescale of 1 and one with a prescale of 2. Each is compared every cycle against an arithmetic run-length model.

// File: rtl/db_pkg.sv
package db_pkg;

  // Bit 1 of the encoding equals the debounced level of the state.
  typedef enum logic [1:0] {
    DB_LOW  = 2'b00,
    DB_RISE = 2'b01,
    DB_HIGH = 2'b11,
    DB_FALL = 2'b10
  } db_state_e;

  function automatic int unsigned db_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic logic db_is_rest(input db_state_e s);
    return (s == DB_LOW) || (s == DB_HIGH);
  endfunction

  function automatic logic db_level_of(input db_state_e s);
    return s[1];
  endfunction

  // True when the synchronised input disagrees with the level a state stands for.
  function automatic logic db_differs(input db_state_e s, input logic in_lvl);
    return in_lvl != db_level_of(s);
  endfunction

endpackage

// File: rtl/db_sync.sv
module db_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/db_tick.sv
module db_tick #(
  parameter int unsigned PRESCALE = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  import db_pkg::*;

  localparam int unsigned PW = db_width(PRESCALE);
  localparam logic [PW-1:0] PLAST = PW'(PRESCALE - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst || clr)          phase <= '0;
    else if (phase == PLAST) phase <= '0;
    else                     phase <= phase + 1'b1;
  end

  assign tick = (phase == PLAST);
endmodule

// File: rtl/db_fsm.sv
module db_fsm #(
  parameter int unsigned DWELL = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_lvl,
  input  logic                          tick,
  output db_pkg::db_state_e             state,
  output logic [db_pkg::db_width(DWELL)-1:0] cnt,
  output logic                          level,
  output logic                          press,
  output logic                          rel,
  output logic                          clr_tick,
  output logic                          abort
);
  import db_pkg::*;

  localparam int unsigned CW = db_width(DWELL);
  localparam logic [CW-1:0] LAST = CW'(DWELL - 1);

  db_state_e     nxt;
  logic [CW-1:0] cnt_n;
  logic          enter_high;
  logic          enter_low;
  logic          dwell_full;

  assign dwell_full = tick && (cnt == LAST);

  always_comb begin
    nxt   = state;
    cnt_n = cnt;
    abort = 1'b0;
    unique case (state)
      DB_LOW: begin
        cnt_n = '0;
        if (in_lvl) nxt = DB_RISE;
      end
      DB_RISE: begin
        if (!in_lvl) begin
          nxt   = DB_LOW;
          cnt_n = '0;
          abort = 1'b1;
        end else if (dwell_full) begin
          nxt   = DB_HIGH;
          cnt_n = '0;
        end else if (tick) begin
          cnt_n = cnt + 1'b1;
        end
      end
      DB_HIGH: begin
        cnt_n = '0;
        if (!in_lvl) nxt = DB_FALL;
      end
      DB_FALL: begin
        if (in_lvl) begin
          nxt   = DB_HIGH;
          cnt_n = '0;
          abort = 1'b1;
        end else if (dwell_full) begin
          nxt   = DB_LOW;
          cnt_n = '0;
        end else if (tick) begin
          cnt_n = cnt + 1'b1;
        end
      end
      default: begin
        nxt   = DB_LOW;
        cnt_n = '0;
      end
    endcase
  end

  assign enter_high = (state == DB_RISE) && (nxt == DB_HIGH);
  assign enter_low  = (state == DB_FALL) && (nxt == DB_LOW);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= DB_LOW;
      cnt   <= '0;
      press <= 1'b0;
      rel   <= 1'b0;
    end else begin
      state <= nxt;
      cnt   <= cnt_n;
      press <= enter_high;
      rel   <= enter_low;
    end
  end

  assign level    = db_level_of(state);
  assign clr_tick = db_is_rest(state);
endmodule

// File: rtl/button_debouncer.sv
module button_debouncer #(
  parameter int unsigned DWELL_TICKS = 1000,
  parameter int unsigned PRESCALE    = 4000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_raw,
  output logic btn_level,
  output logic btn_press,
  output logic btn_release
);
  import db_pkg::*;

  localparam int unsigned CW = db_width(DWELL_TICKS);

  logic          sync_level;
  logic          tick;
  logic          clr_tick;
  logic          abort_evt;
  db_state_e     fsm_state;
  logic [CW-1:0] dwell_cnt;

  db_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (btn_raw),
    .q   (sync_level)
  );

  db_tick #(.PRESCALE(PRESCALE)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr_tick),
    .tick (tick)
  );

  db_fsm #(.DWELL(DWELL_TICKS)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .in_lvl   (sync_level),
    .tick     (tick),
    .state    (fsm_state),
    .cnt      (dwell_cnt),
    .level    (btn_level),
    .press    (btn_press),
    .rel      (btn_release),
    .clr_tick (clr_tick),
    .abort    (abort_evt)
  );
endmodule

// File: rtl/db_checker.sv
module db_checker #(
  parameter int unsigned DWELL = 4
) (
  input logic              clk,
  input logic              rst,
  input db_pkg::db_state_e state,
  input logic              in_lvl,
  input logic [db_pkg::db_width(DWELL)-1:0] cnt,
  input logic              level,
  input logic              press,
  input logic              rel
);
  import db_pkg::*;

  // R4: the dwell counter is idle in both resting states
  p_cnt_rest_r4: assert property (@(posedge clk) disable iff (rst)
    (state == DB_LOW || state == DB_HIGH) |-> (cnt == '0));

  // R3: the counter never passes the dwell limit
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt <= (DWELL - 1)));

  // R4: a return to the old value aborts a rising qualification
  p_abort_rise_r4: assert property (@(posedge clk) disable iff (rst)
    (state == DB_RISE && !in_lvl) |=> (state == DB_LOW && !level));

  // R4: a return to the old value aborts a falling qualification
  p_abort_fall_r4: assert property (@(posedge clk) disable iff (rst)
    (state == DB_FALL && in_lvl) |=> (state == DB_HIGH && level));

  // R5: press lasts one cycle and marks the entry from the rising state
  p_press_once_r5: assert property (@(posedge clk) disable iff (rst)
    press |=> !press);
  p_press_entry_r5: assert property (@(posedge clk) disable iff (rst)
    press |-> (level && $past(state) == DB_RISE));

  // R6: release lasts one cycle and marks the entry from the falling state
  p_rel_once_r6: assert property (@(posedge clk) disable iff (rst)
    rel |=> !rel);
  p_rel_entry_r6: assert property (@(posedge clk) disable iff (rst)
    rel |-> (!level && $past(state) == DB_FALL));

  // R9: strobes are exclusive and every level change carries one
  p_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(press && rel));
  p_change_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    (level != $past(level)) |-> (press || rel));
endmodule

bind button_debouncer db_checker #(.DWELL(DWELL_TICKS)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .state  (fsm_state),
  .in_lvl (sync_level),
  .cnt    (dwell_cnt),
  .level  (btn_level),
  .press  (btn_press),
  .rel    (btn_release)
);

// File: tb/tb_button_debouncer.sv
module tb_db_ref #(
  parameter int D = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic m_level,
  output logic m_press,
  output logic m_rel
);
  logic s1, s2;
  int   run;

  initial begin
    s1 = 0; s2 = 0; run = 0; m_level = 0; m_press = 0; m_rel = 0;
  end

  // Run-length model: level flips after D+1 consecutive differing sampled cycles.
  always @(posedge clk) begin
    if (rst) begin
      s1 = 0; s2 = 0; run = 0; m_level = 0; m_press = 0; m_rel = 0;
    end else begin
      m_press = 0;
      m_rel   = 0;
      if (s2 != m_level) begin
        run = run + 1;
        if (run == D + 1) begin
          m_level = ~m_level;
          m_press = m_level;
          m_rel   = ~m_level;
          run     = 0;
        end
      end else begin
        run = 0;
      end
      s2 = s1;
      s1 = raw;
    end
  end
endmodule

module tb_button_debouncer;
  localparam int DA = 4 * 2;
  localparam int DB = 3 * 1;

  logic clk = 0;
  logic rst = 1;
  logic raw = 0;
  logic lvl_a, prs_a, rel_a;
  logic lvl_b, prs_b, rel_b;
  logic ml_a, mp_a, mr_a, ml_b, mp_b, mr_b;
  int   tests = 0;
  int   fails = 0;
  int   pa = 0, ra = 0, pb = 0, rb = 0;
  bit   done = 0;

  always #2 clk = ~clk;

  button_debouncer #(.DWELL_TICKS(4), .PRESCALE(2), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .btn_raw(raw),
    .btn_level(lvl_a), .btn_press(prs_a), .btn_release(rel_a));

  button_debouncer #(.DWELL_TICKS(3), .PRESCALE(1), .SYNC_STAGES(2)) dut_p1 (
    .clk(clk), .rst(rst), .btn_raw(raw),
    .btn_level(lvl_b), .btn_press(prs_b), .btn_release(rel_b));

  tb_db_ref #(.D(DA)) ref_a (.clk(clk), .rst(rst), .raw(raw),
    .m_level(ml_a), .m_press(mp_a), .m_rel(mr_a));
  tb_db_ref #(.D(DB)) ref_b (.clk(clk), .rst(rst), .raw(raw),
    .m_level(ml_b), .m_press(mp_b), .m_rel(mr_b));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the models (R3, R5, R6, R7, R8)
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(lvl_a == ml_a, "R3/R7 level (prescale 2)", lvl_a, ml_a);
      chk(prs_a == mp_a, "R5 press (prescale 2)", prs_a, mp_a);
      chk(rel_a == mr_a, "R6 release (prescale 2)", rel_a, mr_a);
      chk(lvl_b == ml_b, "R8 level (prescale 1)", lvl_b, ml_b);
      chk(prs_b == mp_b, "R8 press (prescale 1)", prs_b, mp_b);
      chk(rel_b == mr_b, "R8 release (prescale 1)", rel_b, mr_b);
      chk(!(prs_a && rel_a) && !(prs_b && rel_b), "R9 exclusive strobes", prs_a & rel_a, 0);
      pa += prs_a; ra += rel_a; pb += prs_b; rb += rel_b;
    end
  end

  task automatic hold(input logic v, input int n);
    raw = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int bpa, bpb, bra, brb, n, na, nb;
    logic [7:0] lfsr;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk({lvl_a, prs_a, rel_a, lvl_b, prs_b, rel_b} == 6'b0, "R1 reset outputs", lvl_a, 0);
    rst = 0;
    @(negedge clk);
    chk({lvl_a, prs_a, rel_a} == 3'b0, "R1 first cycle after reset", lvl_a, 0);

    // R2: latency of a clean rising step, counted in edges
    raw = 1; n = 0; na = 0; nb = 0;
    while (na == 0 || nb == 0) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (lvl_a && na == 0) na = n;
      if (lvl_b && nb == 0) nb = n;
      if (n > 40) begin na = (na == 0) ? -1 : na; nb = (nb == 0) ? -1 : nb; end
    end
    chk(na == DA + 3, "R2 rise latency prescale 2", na, DA + 3);
    chk(nb == DB + 3, "R2 R8 rise latency prescale 1", nb, DB + 3);
    hold(0, 30);

    // R3/R4: high pulses of every length around the threshold
    for (int L = 1; L <= DA + 3; L++) begin
      bpa = pa; bpb = pb;
      hold(1, L);
      hold(0, 30);
      chk((pa - bpa) == ((L >= DA + 1) ? 1 : 0), "R3 R4 high pulse press count A", pa - bpa, (L >= DA + 1) ? 1 : 0);
      chk((pb - bpb) == ((L >= DB + 1) ? 1 : 0), "R3 R4 high pulse press count B", pb - bpb, (L >= DB + 1) ? 1 : 0);
      chk(lvl_a == 0, "R4 level settles low", lvl_a, 0);
    end

    // R3/R4/R7: low pulses from a settled high level
    hold(1, 30);
    chk(lvl_a == 1, "R7 settled high", lvl_a, 1);
    for (int L = 1; L <= DA + 3; L++) begin
      bra = ra; brb = rb;
      hold(0, L);
      hold(1, 30);
      chk((ra - bra) == ((L >= DA + 1) ? 1 : 0), "R3 R4 low pulse release count A", ra - bra, (L >= DA + 1) ? 1 : 0);
      chk((rb - brb) == ((L >= DB + 1) ? 1 : 0), "R3 R4 low pulse release count B", rb - brb, (L >= DB + 1) ? 1 : 0);
      chk(lvl_a == 1, "R7 level settles high", lvl_a, 1);
    end

    // R3/R9: pseudo-random bounce burst, checked by the models
    lfsr = 8'hA5;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      hold((lfsr[2:0] == 3'b000) ? ~raw : raw, 1 + (lfsr[6:4] & 3'd3));
    end
    hold(0, 40);

    // R1: reset in the middle of a rising qualification
    hold(1, 6);
    rst = 1;
    @(negedge clk);
    chk({lvl_a, prs_a, rel_a, lvl_b, prs_b, rel_b} == 6'b0, "R1 reset mid-qualification", lvl_a, 0);
    hold(0, 2);
    rst = 0;
    @(negedge clk);
    chk({lvl_a, prs_a, rel_a} == 3'b0, "R1 after mid reset", lvl_a, 0);
    hold(0, 30);
    chk(lvl_a == 0 && lvl_b == 0, "R1 stays low after reset", lvl_a, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule